// File: doc/BRIEF.md
# Per-Bunch DC-Removal IIR Filter

This block takes the position samples of a multibunch feedback loop and removes the slow, near-DC part of each bunch's signal. One signed 8-bit sample arrives per clock. It is tagged with the index of the bunch it belongs to, and the index steps through a fixed number of bunches per turn. For every bunch the block keeps its own leaky accumulator in a state memory addressed by bunch index. It emits a 16-bit value equal to that accumulator minus eight times the sample. A steady offset on any single bunch therefore decays to zero, while the oscillation component passes through negated and scaled.

An enable input chooses between the filtered result and a plain bypass, which outputs minus eight times the sample. The accumulators keep updating in either setting, so switching the enable never leaves a stale state behind. After reset, and after a pulse on the clear input, the block walks the whole state memory and writes zeros. Samples are refused until that walk is complete.

Top module: `dcr_iir_top`

## Requirements
- R1: After reset is released, the first NUM_BUNCH clock edges clear every bunch state to zero. Samples captured on those edges are discarded and produce no output, and `out_valid_o` stays low.
- R2: A sample accepted at clock edge t produces exactly one `out_valid_o` pulse, visible in the cycle after edge t+1 (two-cycle latency). No other pulses occur.
- R3: Each bunch b has its own 32-bit two's-complement accumulator. On every accepted sample x for bunch b it becomes acc − (acc >>> 3) + x·2^20, where >>> is an arithmetic shift and x is the signed 8-bit input. Samples for other bunches leave it unchanged.
- R4: With `en_i` = 1, the output is bits [31:16] of (new acc − x·2^23), which rounds toward negative infinity.
- R5: With `en_i` = 0, the output is bits [31:16] of −x·2^23, which equals −128·x. The accumulator still updates as in R3.
- R6: A constant sample held on one bunch drives that bunch's enabled output to exactly 0 within 200 of its samples.
- R7: A sample whose bunch index is NUM_BUNCH or larger is ignored. It produces no output and changes no state.
- R8: Two samples for the same bunch on consecutive clocks are both processed in order. The second one sees the accumulator left by the first.
- R9: `clr_i` high at an edge discards the sample captured at that edge and suppresses the output of the sample accepted one edge earlier. It then repeats the R1 zeroing walk over the next NUM_BUNCH edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear: restarts the state-zeroing walk |
| en_i | input | 1 | 1 selects the filtered output, 0 selects bypass |
| in_valid_i | input | 1 | Sample strobe |
| in_bunch_i | input | IDX_W | Bunch index of the sample, 0 to NUM_BUNCH−1 |
| in_sample_i | input | SAMPLE_W | Signed sample |
| out_valid_o | output | 1 | Result strobe |
| out_sample_o | output | OUT_W | Signed filtered result |

## Verification
A sample captured at one rising edge has its result registered at the next-but-one edge, so the bench compares outputs two stimulus cycles after the stimulus that caused them. To do this it holds a two-deep queue of expected results. It drives inputs and samples outputs on falling edges. Any sample still in flight when clear is asserted is removed from that queue. The zeroing walk is modelled as a countdown of NUM_BUNCH edges, and samples during the walk are expected to yield nothing. Back-to-back samples to one bunch test the case where a result is due before the state write of the previous sample has reached the memory.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_SWEEP = 1'b1
  } seq_state_e;

endpackage

// File: rtl/dcr_state_ram.sv
module dcr_state_ram #(
  parameter int DEPTH = 480,
  parameter int AW    = 9,
  parameter int DW    = 32
) (
  input  logic          clk_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i
);

  logic [DW-1:0] mem_q [DEPTH];

  // read returns the old word when the same address is written on this edge
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
    if (rd_en_i) begin
      rd_data_o <= mem_q[rd_addr_i];
    end
  end

endmodule

// File: rtl/dcr_clear_seq.sv
module dcr_clear_seq import dcr_pkg::*; #(
  parameter int NUM_BUNCH = 480,
  parameter int IDX_W     = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic             busy_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_addr_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUNCH - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (clr_i) begin
      state_d = SEQ_SWEEP;
      cnt_d   = '0;
    end else if (state_q == SEQ_SWEEP) begin
      if (cnt_q == LAST_IDX) begin
        state_d = SEQ_IDLE;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_SWEEP;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o    = (state_q == SEQ_SWEEP);
  assign wr_en_o   = (state_q == SEQ_SWEEP);
  assign wr_addr_o = cnt_q;

endmodule

// File: rtl/dcr_iir_math.sv
module dcr_iir_math #(
  parameter int SAMPLE_W   = 8,
  parameter int ACC_W      = 32,
  parameter int OUT_W      = 16,
  parameter int IN_SHIFT   = 20,
  parameter int GAIN_SHIFT = 3
) (
  input  logic signed [ACC_W-1:0]    acc_old_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       en_i,
  output logic signed [ACC_W-1:0]    acc_new_o,
  output logic signed [OUT_W-1:0]    result_o
);

  logic signed [ACC_W-1:0] x_ext;
  logic signed [ACC_W-1:0] x_in;
  logic signed [ACC_W-1:0] x_gain;
  logic signed [ACC_W-1:0] y_full;

  always_comb begin
    x_ext     = {{(ACC_W-SAMPLE_W){sample_i[SAMPLE_W-1]}}, sample_i};
    x_in      = x_ext <<< IN_SHIFT;
    x_gain    = x_ext <<< (IN_SHIFT + GAIN_SHIFT);
    // leak of 1/2^GAIN_SHIFT by shift-and-subtract, no multiplier
    acc_new_o = acc_old_i - (acc_old_i >>> GAIN_SHIFT) + x_in;
    y_full    = en_i ? (acc_new_o - x_gain) : (-x_gain);
    result_o  = y_full[ACC_W-1 -: OUT_W];
  end

endmodule

// File: rtl/dcr_iir_top.sv
module dcr_iir_top import dcr_pkg::*; #(
  parameter int NUM_BUNCH  = 480,
  parameter int SAMPLE_W   = 8,
  parameter int ACC_W      = 32,
  parameter int OUT_W      = 16,
  parameter int IN_SHIFT   = 20,
  parameter int GAIN_SHIFT = 3,
  localparam int IDX_W     = (NUM_BUNCH > 1) ? $clog2(NUM_BUNCH) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                en_i,
  input  logic                in_valid_i,
  input  logic [IDX_W-1:0]    in_bunch_i,
  input  logic [SAMPLE_W-1:0] in_sample_i,
  output logic                out_valid_o,
  output logic [OUT_W-1:0]    out_sample_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUNCH - 1);

  logic                busy;
  logic                sweep_we;
  logic [IDX_W-1:0]    sweep_addr;
  logic                accept;
  logic [ACC_W-1:0]    rd_data;
  logic [ACC_W-1:0]    acc_old;
  logic [ACC_W-1:0]    acc_new;
  logic [OUT_W-1:0]    result;
  logic                ram_we;
  logic [IDX_W-1:0]    ram_waddr;
  logic [ACC_W-1:0]    ram_wdata;

  logic                s1_valid_q, s1_valid_d;
  logic                s1_fwd_q, s1_fwd_d;
  logic [IDX_W-1:0]    s1_idx_q;
  logic [SAMPLE_W-1:0] s1_x_q;
  logic                s1_en_q;
  logic [ACC_W-1:0]    s1_fwd_acc_q;
  logic                out_valid_q, out_valid_d;
  logic [OUT_W-1:0]    out_sample_q;

  dcr_clear_seq #(
    .NUM_BUNCH (NUM_BUNCH),
    .IDX_W     (IDX_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .busy_o    (busy),
    .wr_en_o   (sweep_we),
    .wr_addr_o (sweep_addr)
  );

  dcr_state_ram #(
    .DEPTH (NUM_BUNCH),
    .AW    (IDX_W),
    .DW    (ACC_W)
  ) u_ram (
    .clk_i     (clk_i),
    .rd_en_i   (accept),
    .rd_addr_i (in_bunch_i),
    .rd_data_o (rd_data),
    .wr_en_i   (ram_we),
    .wr_addr_i (ram_waddr),
    .wr_data_i (ram_wdata)
  );

  dcr_iir_math #(
    .SAMPLE_W   (SAMPLE_W),
    .ACC_W      (ACC_W),
    .OUT_W      (OUT_W),
    .IN_SHIFT   (IN_SHIFT),
    .GAIN_SHIFT (GAIN_SHIFT)
  ) u_math (
    .acc_old_i (acc_old),
    .sample_i  (s1_x_q),
    .en_i      (s1_en_q),
    .acc_new_o (acc_new),
    .result_o  (result)
  );

  // next-state logic
  always_comb begin
    accept      = in_valid_i && !busy && !clr_i && (in_bunch_i <= LAST_IDX);
    s1_valid_d  = accept;
    // the stage-1 write lands on the same edge as this read: bypass it
    s1_fwd_d    = accept && s1_valid_q && (s1_idx_q == in_bunch_i);
    acc_old     = s1_fwd_q ? s1_fwd_acc_q : rd_data;
    out_valid_d = s1_valid_q && !clr_i;
    if (sweep_we) begin
      ram_we    = 1'b1;
      ram_waddr = sweep_addr;
      ram_wdata = '0;
    end else begin
      ram_we    = s1_valid_q && !clr_i;
      ram_waddr = s1_idx_q;
      ram_wdata = acc_new;
    end
  end

  // control registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q  <= 1'b0;
      s1_fwd_q    <= 1'b0;
      out_valid_q <= 1'b0;
    end else begin
      s1_valid_q  <= s1_valid_d;
      s1_fwd_q    <= s1_fwd_d;
      out_valid_q <= out_valid_d;
    end
  end

  // payload registers, loaded only on accepted samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_idx_q     <= '0;
      s1_x_q       <= '0;
      s1_en_q      <= 1'b0;
      s1_fwd_acc_q <= '0;
    end else if (accept) begin
      s1_idx_q     <= in_bunch_i;
      s1_x_q       <= in_sample_i;
      s1_en_q      <= en_i;
      s1_fwd_acc_q <= acc_new;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_sample_q <= '0;
    end else if (s1_valid_q) begin
      out_sample_q <= result;
    end
  end

  assign out_valid_o  = out_valid_q;
  assign out_sample_o = out_sample_q;

endmodule

// File: rtl/dcr_iir_chk.sv
module dcr_iir_chk #(
  parameter int NUM_BUNCH  = 480,
  parameter int SAMPLE_W   = 8,
  parameter int ACC_W      = 32,
  parameter int OUT_W      = 16,
  parameter int IN_SHIFT   = 20,
  parameter int GAIN_SHIFT = 3,
  parameter int IDX_W      = 9
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                clr_i,
  input logic                en_i,
  input logic                in_valid_i,
  input logic [IDX_W-1:0]    in_bunch_i,
  input logic [SAMPLE_W-1:0] in_sample_i,
  input logic                busy,
  input logic                out_valid_o,
  input logic [OUT_W-1:0]    out_sample_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUNCH - 1);
  localparam int BYP_SH = IN_SHIFT + GAIN_SHIFT - (ACC_W - OUT_W);

  logic [1:0]              age_q;
  logic                    take_now;
  logic signed [OUT_W-1:0] sx;
  logic signed [OUT_W-1:0] byp_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= 2'd0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  always_comb begin
    take_now = in_valid_i && !busy && !clr_i && (in_bunch_i <= LAST_IDX);
    sx       = {{(OUT_W-SAMPLE_W){in_sample_i[SAMPLE_W-1]}}, in_sample_i};
    byp_now  = -(sx <<< BYP_SH);
  end

  // R1: nothing leaves the block while the state walk runs
  assert_quiet_during_sweep_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !out_valid_o);

  // R2: one pulse per accepted sample, two cycles later
  assert_two_cycle_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (out_valid_o == ($past(take_now, 2) && !$past(clr_i, 1))));

  // R5: bypass result is -128 times the sample
  assert_bypass_value_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q == 2'd3) && out_valid_o && !$past(en_i, 2)) |-> ($signed(out_sample_o) == $past(byp_now, 2)));

  // R7: out-of-range index produces no pulse
  assert_range_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (in_bunch_i > LAST_IDX) && !$past(in_valid_i)) |-> ##2 !out_valid_o);

  // R9: clear kills the pending output and starts the walk
  assert_clear_kill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!out_valid_o && busy));

endmodule

bind dcr_iir_top dcr_iir_chk #(
  .NUM_BUNCH  (NUM_BUNCH),
  .SAMPLE_W   (SAMPLE_W),
  .ACC_W      (ACC_W),
  .OUT_W      (OUT_W),
  .IN_SHIFT   (IN_SHIFT),
  .GAIN_SHIFT (GAIN_SHIFT),
  .IDX_W      (IDX_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clr_i        (clr_i),
  .en_i         (en_i),
  .in_valid_i   (in_valid_i),
  .in_bunch_i   (in_bunch_i),
  .in_sample_i  (in_sample_i),
  .busy         (busy),
  .out_valid_o  (out_valid_o),
  .out_sample_o (out_sample_o)
);

// File: tb/tb_dcr_iir_top.sv
module tb_dcr_iir_top;

  localparam int NB = 5;
  localparam int IW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          clr_i;
  logic          en_i;
  logic          in_valid_i;
  logic [IW-1:0] in_bunch_i;
  logic [7:0]    in_sample_i;
  logic          out_valid_o;
  logic [15:0]   out_sample_o;

  dcr_iir_top #(.NUM_BUNCH(NB)) dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr_i),
    .en_i         (en_i),
    .in_valid_i   (in_valid_i),
    .in_bunch_i   (in_bunch_i),
    .in_sample_i  (in_sample_i),
    .out_valid_o  (out_valid_o),
    .out_sample_o (out_sample_o)
  );

  always #5 clk_i = ~clk_i;

  int     n_vec  = 0;
  int     n_fail = 0;
  longint macc [NB];
  int     busy_left;
  bit     p1v, p2v, p1z, p2z;
  longint p1d, p2d;
  string  p1t, p2t;
  int     seed = 7;
  bit     done = 1'b0;

  function automatic int rnd8();
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 16) & 255) - 128;
  endfunction

  // check the result due now, then apply one stimulus and model it
  task automatic step(input bit v, input int idx, input int x, input bit en,
                      input bit clr, input string tag, input bit zero = 1'b0);
    bit     ok;
    longint a, y;
    @(negedge clk_i);
    if (p2v || out_valid_o) begin
      n_vec++;
      if (out_valid_o !== p2v) begin
        n_fail++;
        $display("FAIL %s/R2: out_valid=%0b expected %0b", p2t, out_valid_o, p2v);
      end else if (longint'($signed(out_sample_o)) != p2d) begin
        n_fail++;
        $display("FAIL %s: out_sample=%0d expected %0d", p2t, $signed(out_sample_o), p2d);
      end else if (p2z && out_sample_o != 16'd0) begin
        n_fail++;
        $display("FAIL R6: out_sample=%0d expected 0", $signed(out_sample_o));
      end
    end
    ok  = v && !clr && (busy_left == 0) && (idx < NB);
    p2v = clr ? 1'b0 : p1v;
    p2d = p1d; p2t = p1t; p2z = p1z;
    if (clr) begin
      for (int i = 0; i < NB; i++) macc[i] = 0;
      busy_left = NB;
    end else if (busy_left > 0) begin
      busy_left--;
    end
    p1v = ok; p1t = tag; p1z = zero; p1d = 0;
    if (ok) begin
      a = macc[idx];
      a = a - (a >>> 3) + (longint'(x) <<< 20);
      macc[idx] = a;
      y = en ? (a - (longint'(x) <<< 23)) : -(longint'(x) <<< 23);
      p1d = y >>> 16;
    end
    in_valid_i  = v;
    in_bunch_i  = IW'(idx);
    in_sample_i = 8'(x);
    en_i        = en;
    clr_i       = clr;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; clr_i = 1'b0; en_i = 1'b0; in_valid_i = 1'b0;
    in_bunch_i = '0; in_sample_i = '0;
    p1v = 0; p2v = 0; p1z = 0; p2z = 0; p1d = 0; p2d = 0; p1t = "R1"; p2t = "R1";
    for (int i = 0; i < NB; i++) macc[i] = 0;
    repeat (3) @(negedge clk_i);
    n_vec++;
    if (out_valid_o !== 1'b0 || out_sample_o !== 16'd0) begin
      n_fail++;
      $display("FAIL R1: reset outputs valid=%0b data=%0d expected 0/0", out_valid_o, out_sample_o);
    end
    rst_ni    = 1'b1;
    busy_left = NB - 1;

    // R1: samples during the zeroing walk vanish
    for (int k = 0; k < NB + 2; k++) step(1, k % NB, 50, 1, 0, "R1");

    // R5: bypass over every sample value, bunches cycling
    for (int k = 0; k < 256; k++) step(1, k % NB, k - 128, 0, 0, "R5");

    // R3/R4: filtered, pseudo-random samples continuing from bypass state
    for (int k = 0; k < 300; k++) begin
      if (k % 7 == 3) step(0, 0, 0, 1, 0, "R2");
      else step(1, k % NB, rnd8(), 1, 0, "R3/R4");
    end

    // R6: per-bunch constant levels settle to zero
    for (int t = 0; t < 200; t++)
      for (int b = 0; b < NB; b++)
        step(1, b, (b == 0) ? 127 : (b == 1) ? -128 : (b * 37 - 60), 1, 0, "R6", t == 199);

    // R7: out-of-range indices interleaved
    for (int k = 0; k < 60; k++) begin
      if (k % 3 == 1) step(1, NB + (k % (8 - NB)), rnd8(), 1, 0, "R7");
      else step(1, k % NB, rnd8(), 1, 0, "R7");
    end

    // R8: same bunch on consecutive clocks, then with one gap
    for (int k = 0; k < 40; k++) step(1, 2, rnd8(), 1, 0, "R8");
    for (int k = 0; k < 40; k++) step(1, (k / 2) % 2, rnd8(), k % 3 != 0, 0, "R8");

    // R9: clear mid-stream, samples during the walk, then restart from zero
    step(1, 1, 33, 1, 0, "R9");
    step(1, 2, 44, 1, 1, "R9");
    for (int k = 0; k < NB; k++) step(1, k, 90, 1, 0, "R9");
    for (int k = 0; k < 3 * NB; k++) step(1, k % NB, rnd8(), 1, 0, "R9");

    step(0, 0, 0, 1, 0, "R2");
    step(0, 0, 0, 1, 0, "R2");
    step(0, 0, 0, 1, 0, "R2");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule